// File: doc/BRIEF.md
# Clock Mode Selection Controller

This block turns one fast reference clock into two single-cycle enable strobes, one for the processor and one for the peripherals. A 3-bit mode code picks the divide ratio for each strobe and chooses between the fast reference and a slow tick. The slow tick is a one-cycle pulse, synchronous to the reference clock, that marks each edge of a 32.768 kHz source. A second 3-bit code divides that slow tick further. A doubler bit selects the fast base rate. The reference clock is modelled as twice the oscillator rate. With the doubler off, a base tick is produced on every second reference cycle. With the doubler on, a base tick is produced on every reference cycle. The strobes are enables for logic that runs on the reference clock. They are not gated clocks.

Software loads the three codes through a plain write port into pending registers. The pending codes become active together at the last cycle of a processor period, which is the cycle in which `cpu_en` pulses. No strobe is ever cut short or repeated by a mode change. The processor ratio is always a multiple of the peripheral ratio, and both counters restart together. Because of this, every processor strobe coincides with a peripheral strobe.

Top module: `clkmode_ctrl`

## Requirements
- R1: With mode code 000 and the doubler off, `cpu_en` and `per_en` each pulse once every 16 reference cycles, which is base divided by 8.
- R2: With mode code 001, `cpu_en` pulses at base divided by 8 and `per_en` pulses on every base tick. With the doubler off, these are every 16 and every 2 reference cycles.
- R3: Mode codes 010, 011, 110 and 111 divide the base by 1, 2, 4 and 6 for both strobes. With the doubler off, these are intervals of 2, 4, 8 and 12 reference cycles.
- R4: With the doubler bit set to 1, the base tick occurs on every reference cycle. Codes 010, 110, 111 and 000 then give intervals of 1, 4, 6 and 8 cycles. These equal twice the oscillator rate, oscillator/2, oscillator/3 and oscillator/4.
- R5: Mode codes 100 and 101 drive both strobes from the divided slow tick only. Each strobe falls in the same cycle as the slow tick that completes the count, and the fast base has no effect.
- R6: Slow divider code 000 passes every slow tick. Codes 100, 101, 110 and 111 keep one slow tick in 2, 4, 8 and 16.
- R7: Slow divider codes 001, 010 and 011 are reserved. They act like 000, and `slow_div_bad` is high from the cycle after such a write until a legal code is written.
- R8: A new configuration becomes active in the cycle after a `cpu_en` pulse. The first interval measured from that pulse already has the full new length.
- R9: `fast_off` rises in the cycle after the `cpu_en` pulse that activates mode 101, and never before that. It falls in the same way when the block leaves mode 101.
- R10: While `rst_n` is low, all outputs are 0 and the codes are mode 000, slow divider 000 and doubler off. The first `cpu_en` after release comes 15 cycles after the last cycle of reset.
- R11: Write address 0 loads the mode from `wr_data[2:0]`. Address 1 loads the slow divider from `wr_data[2:0]`. Address 2 loads the doubler from `wr_data[0]`. Address 3 is ignored. A write in the same cycle as a `cpu_en` pulse only takes effect at the following boundary.
- R12: Every `cpu_en` pulse coincides with a `per_en` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock, twice the oscillator rate |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 slow divider, 2 doubler |
| wr_data | input | 3 | Write value |
| slow_tick | input | 1 | One-cycle pulse per slow-clock edge |
| cpu_en | output | 1 | Processor clock-enable strobe |
| per_en | output | 1 | Peripheral clock-enable strobe |
| fast_off | output | 1 | High while mode 101 is active |
| slow_div_bad | output | 1 | Reserved slow divider code is loaded |

## Verification
A register write and a period boundary can fall in the same cycle. The pending register then takes the new value while the active register copies the old one. The bench provokes this by writing a new mode in exactly the cycle in which `cpu_en` pulses under a divide-by-1 setting. It then expects one more old-length interval followed by new-length intervals. A slow tick can also coincide with a boundary while the source is switching. For that case the bench judges the first fast interval after leaving slow mode, which must have its exact length.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int MODE_W = 3;
  localparam int SDIV_W = 3;
  localparam int CNT_W  = 4;
  localparam int SCNT_W = 4;

  localparam logic [1:0] ADDR_MODE = 2'd0;
  localparam logic [1:0] ADDR_SDIV = 2'd1;
  localparam logic [1:0] ADDR_DBL  = 2'd2;

  localparam logic [MODE_W-1:0] MODE_SLOW_NOFAST = 3'b101;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [SDIV_W-1:0] sdiv;
    logic              dbl;
  } clk_cfg_t;

  function automatic logic mode_is_slow(input logic [MODE_W-1:0] m);
    return m[2:1] == 2'b10;
  endfunction

  function automatic logic [CNT_W-1:0] cpu_ratio(input logic [MODE_W-1:0] m);
    case (m)
      3'b000, 3'b001: return CNT_W'(8);
      3'b011:         return CNT_W'(2);
      3'b110:         return CNT_W'(4);
      3'b111:         return CNT_W'(6);
      default:        return CNT_W'(1);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] per_ratio(input logic [MODE_W-1:0] m);
    if (m == 3'b001) return CNT_W'(1);
    return cpu_ratio(m);
  endfunction

  function automatic logic [SCNT_W:0] slow_ratio(input logic [SDIV_W-1:0] c);
    case (c)
      3'b100:  return (SCNT_W+1)'(2);
      3'b101:  return (SCNT_W+1)'(4);
      3'b110:  return (SCNT_W+1)'(8);
      3'b111:  return (SCNT_W+1)'(16);
      default: return (SCNT_W+1)'(1);
    endcase
  endfunction

  function automatic logic sdiv_reserved(input logic [SDIV_W-1:0] c);
    return (c != '0) && !c[2];
  endfunction
endpackage

// File: rtl/clkmode_regs.sv
module clkmode_regs
  import clkmode_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int FIELD_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [FIELD_W-1:0] wr_data,
  input  logic               commit,
  output clk_cfg_t           act,
  output logic               sdiv_bad
);
  clk_cfg_t pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      act      <= '0;
      sdiv_bad <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          ADDR_MODE: pend.mode <= wr_data[MODE_W-1:0];
          ADDR_SDIV: begin
            pend.sdiv <= wr_data[SDIV_W-1:0];
            sdiv_bad  <= sdiv_reserved(wr_data[SDIV_W-1:0]);
          end
          ADDR_DBL:  pend.dbl <= wr_data[0];
          default:   ;
        endcase
      end
      // pending set moves to active only at a processor period boundary
      if (commit) act <= pend;
    end
  end
endmodule

// File: rtl/clkmode_base.sv
module clkmode_base
  import clkmode_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  clk_cfg_t cfg,
  input  logic     slow_tick,
  input  logic     restart,
  output logic     src_tick
);
  logic              ph;
  logic [SCNT_W-1:0] scnt;
  logic [SCNT_W:0]   sratio;
  logic              slow_hit;
  logic              fast_tick;

  assign sratio    = slow_ratio(cfg.sdiv);
  assign slow_hit  = slow_tick && ({1'b0, scnt} == sratio - 1'b1);
  assign fast_tick = cfg.dbl | ph;
  assign src_tick  = mode_is_slow(cfg.mode) ? slow_hit : fast_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= 1'b0;
      scnt <= '0;
    end else begin
      ph <= (restart || cfg.dbl) ? 1'b0 : ~ph;
      if (restart)        scnt <= '0;
      else if (slow_tick) scnt <= slow_hit ? '0 : scnt + 1'b1;
    end
  end
endmodule

// File: rtl/clkmode_div.sv
module clkmode_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         restart,
  input  logic [W-1:0] ratio,
  output logic         en
);
  logic [W-1:0] cnt;

  assign en = tick && (cnt == ratio - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (tick)    cnt <= en ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/clkmode_ctrl.sv
module clkmode_ctrl
  import clkmode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [2:0] wr_data,
  input  logic       slow_tick,
  output logic       cpu_en,
  output logic       per_en,
  output logic       fast_off,
  output logic       slow_div_bad
);
  localparam int LANES = 2;

  clk_cfg_t               act;
  logic                   src_tick;
  logic [LANES-1:0]       lane_en;
  logic [CNT_W-1:0]       lane_ratio [LANES];

  assign lane_ratio[0] = cpu_ratio(act.mode);
  assign lane_ratio[1] = per_ratio(act.mode);

  clkmode_regs #(.ADDR_W(2), .FIELD_W(3)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(lane_en[0]), .act(act),
    .sdiv_bad(slow_div_bad)
  );

  clkmode_base u_base (
    .clk(clk), .rst_n(rst_n), .cfg(act), .slow_tick(slow_tick),
    .restart(lane_en[0]), .src_tick(src_tick)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    clkmode_div #(.W(CNT_W)) u_div (
      .clk(clk), .rst_n(rst_n), .tick(src_tick), .restart(lane_en[0]),
      .ratio(lane_ratio[g]), .en(lane_en[g])
    );
  end

  assign cpu_en   = lane_en[0];
  assign per_en   = lane_en[1];
  assign fast_off = (act.mode == MODE_SLOW_NOFAST);
endmodule

// File: rtl/clkmode_ctrl_chk.sv
module clkmode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic [2:0] wr_data,
  input logic       slow_tick,
  input logic       cpu_en,
  input logic       per_en,
  input logic       fast_off,
  input logic       slow_div_bad
);
  p_align_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_en |-> per_en);

  p_slowcpu_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_off && cpu_en) |-> slow_tick);

  p_slowper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast_off && per_en) |-> slow_tick);

  p_bad_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && wr_data != 3'd0 && !wr_data[2]) |=> slow_div_bad);

  p_bad_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd1 && (wr_data == 3'd0 || wr_data[2])) |=> !slow_div_bad);

  p_off_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fast_off) |-> $past(cpu_en));

  p_off_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fast_off) |-> $past(cpu_en));
endmodule

bind clkmode_ctrl clkmode_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .slow_tick(slow_tick), .cpu_en(cpu_en),
  .per_en(per_en), .fast_off(fast_off), .slow_div_bad(slow_div_bad)
);

// File: tb/sim_clkmode_ctrl.sv
module sim_clkmode_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [2:0] wr_data = '0;
  logic       slow_tick = 1'b0;
  logic       cpu_en, per_en, fast_off, slow_div_bad;

  always #10 clk = ~clk;

  clkmode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .slow_tick(slow_tick), .cpu_en(cpu_en),
    .per_en(per_en), .fast_off(fast_off), .slow_div_bad(slow_div_bad)
  );

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  string cur_tag = "R10";
  int    qc[$];
  int    qp[$];
  bit    armed = 1'b0;
  int    last_c = 0;
  int    last_p = 0;
  logic [2:0] prev_mode = 3'b000;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, got, exp);
    end
  endtask

  // slow tick: one cycle high in every five
  initial begin
    forever begin
      repeat (4) @(posedge clk);
      #1 slow_tick = 1'b1;
      @(posedge clk);
      #1 slow_tick = 1'b0;
    end
  end

  // monitor: pops expected intervals and compares
  always @(negedge clk) begin
    if (rst_n) begin
      if (cpu_en) begin
        chk("R12", int'(per_en), 1, "per_en with cpu_en");
        if (armed && qc.size() > 0) begin
          int e;
          e = qc.pop_front();
          if (e != 0) chk(cur_tag, cyc - last_c, e, "cpu interval");
        end
        last_c = cyc;
      end
      if (per_en) begin
        if (armed && qp.size() > 0) begin
          int e;
          e = qp.pop_front();
          if (e != 0) chk(cur_tag, cyc - last_p, e, "per interval");
        end
        last_p = cyc;
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [2:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: loads a configuration and pushes the intervals it must produce
  task automatic run_cfg(input string tag, input logic [2:0] mode, input logic [2:0] sdiv,
                         input logic dbl, input int ec, input int ep, input int n,
                         input bit exact);
    int np;
    armed = 1'b0;
    cur_tag = tag;
    wr(2'd1, sdiv);
    wr(2'd2, {2'b00, dbl});
    wr(2'd0, mode);
    chk("R7", int'(slow_div_bad), int'(sdiv != 3'd0 && !sdiv[2]), "slow_div_bad");
    while (!cpu_en) @(negedge clk);
    chk("R9", int'(fast_off), int'(prev_mode == 3'b101), "fast_off before commit");
    #1;
    qc.delete();
    qp.delete();
    np = n * ec / ep;
    for (int i = 0; i < n; i++) qc.push_back((i == 0 && !exact) ? 0 : ec);
    for (int i = 0; i < np; i++) qp.push_back((i == 0 && !exact) ? 0 : ep);
    armed = 1'b1;
    @(negedge clk);
    chk("R9", int'(fast_off), int'(mode == 3'b101), "fast_off after commit");
    prev_mode = mode;
    while (qc.size() > 0 || qp.size() > 0) @(negedge clk);
    armed = 1'b0;
  endtask

  initial begin
    wait (cyc >= 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected below %0d", cyc, 100000);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int rel;
    repeat (3) @(negedge clk);
    chk("R10", int'(cpu_en), 0, "cpu_en in reset");
    chk("R10", int'(per_en), 0, "per_en in reset");
    chk("R10", int'(fast_off), 0, "fast_off in reset");
    chk("R10", int'(slow_div_bad), 0, "slow_div_bad in reset");
    rst_n = 1'b1;
    rel = cyc;
    @(negedge clk);
    while (!cpu_en) @(negedge clk);
    chk("R10", cyc - rel, 15, "first cpu_en after reset");

    run_cfg("R1", 3'b000, 3'b000, 1'b0, 16, 16, 3, 1'b1);
    run_cfg("R2", 3'b001, 3'b000, 1'b0, 16, 2, 3, 1'b1);
    run_cfg("R3", 3'b010, 3'b000, 1'b0, 2, 2, 4, 1'b1);
    run_cfg("R3", 3'b011, 3'b000, 1'b0, 4, 4, 3, 1'b1);
    run_cfg("R3", 3'b110, 3'b000, 1'b0, 8, 8, 3, 1'b1);
    run_cfg("R3", 3'b111, 3'b000, 1'b0, 12, 12, 3, 1'b1);
    run_cfg("R4", 3'b010, 3'b000, 1'b1, 1, 1, 4, 1'b1);
    run_cfg("R4", 3'b110, 3'b000, 1'b1, 4, 4, 3, 1'b1);
    run_cfg("R4", 3'b111, 3'b000, 1'b1, 6, 6, 3, 1'b1);
    run_cfg("R4", 3'b000, 3'b000, 1'b1, 8, 8, 3, 1'b1);
    run_cfg("R5", 3'b100, 3'b000, 1'b0, 5, 5, 4, 1'b0);
    run_cfg("R6", 3'b100, 3'b100, 1'b0, 10, 10, 3, 1'b0);
    run_cfg("R6", 3'b100, 3'b111, 1'b0, 80, 80, 3, 1'b0);
    run_cfg("R7", 3'b100, 3'b010, 1'b0, 5, 5, 4, 1'b0);
    run_cfg("R9", 3'b101, 3'b101, 1'b0, 20, 20, 3, 1'b0);
    // R8: leaving the slow source, the first fast interval is exact
    run_cfg("R8", 3'b010, 3'b000, 1'b0, 2, 2, 3, 1'b1);

    // R11: mode write in the same cycle as a boundary waits one more period
    armed = 1'b0;
    cur_tag = "R11";
    while (!cpu_en) @(negedge clk);
    #1;
    qc.delete();
    qp.delete();
    qc.push_back(2); qc.push_back(8); qc.push_back(8);
    qp.push_back(2); qp.push_back(8); qp.push_back(8);
    armed = 1'b1;
    wr_en = 1'b1; wr_addr = 2'd0; wr_data = 3'b110;
    @(negedge clk);
    wr_en = 1'b0;
    while (qc.size() > 0 || qp.size() > 0) @(negedge clk);
    armed = 1'b0;

    // R11: address 3 is ignored
    wr(2'd3, 3'b010);
    cur_tag = "R11";
    while (!cpu_en) @(negedge clk);
    #1;
    qc.delete(); qp.delete();
    qc.push_back(8); qc.push_back(8);
    qp.push_back(8); qp.push_back(8);
    armed = 1'b1;
    while (qc.size() > 0 || qp.size() > 0) @(negedge clk);
    armed = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule